// File: doc/BRIEF.md
# Configurable Pixel Word Packer

This block sits behind the camera sample qualifier. It collects qualified pixel samples into 32-bit little-endian words for a DMA or FIFO write port. All of its logic runs in one clock domain. Each cycle it sees a 14-bit sample bus with a valid strobe and three single-cycle markers: frame start, line start and frame end. It produces a 32-bit word together with a one-cycle word strobe.

A frame-start marker latches a small configuration vector. The vector holds:
- the sample width;
- an in-line decimation mode and its phase, which act on narrow samples only;
- a line decimation enable and its phase;
- a compressed-stream flag.

Narrow 8-bit samples fill four byte lanes. Wider samples fill two 16-bit halves, and the upper bits of each half are zero. At the end of a frame, a partly filled word is treated in one of two ways. A compressed stream emits it zero-padded. An uncompressed stream drops it.

Top module: `pixel_word_packer`

## Requirements
- R1: After reset, wordValid is 0 and wordOut is 0.
- R2: With width code 00, sampleIn[7:0] of four kept samples fill wordOut[7:0], [15:8], [23:16] and [31:24] in arrival order, and sampleIn[13:8] has no effect.
- R3: With width codes 01, 10 and 11 (10, 12 and 14 bits), two kept samples fill wordOut[15:0] and then wordOut[31:16]. Each sample is masked to its width, and the remaining bits of its half are zero.
- R4: With width code 00, the byte-select mode chooses which samples are kept, using a position counter p that counts valid samples on kept lines modulo 4. Mode 00 keeps all samples. Mode 01 keeps those with p mod 2 equal to the phase. Mode 10 keeps those with p equal to the phase. Mode 11 keeps those with p div 2 equal to the phase.
- R5: Byte phase 0 keeps the first sample after a frame or line start, and byte phase 1 drops it.
- R6: With any width code other than 00, the byte-select mode and phase have no effect and every sample on a kept line is packed.
- R7: With line select enabled, only lines whose index parity equals the line phase are packed. The lines after frame start are indexed 0, 1, 2 and so on. The first line-start marker after a frame start does not advance the index.
- R8: A line-start marker resets the position counter. It does not reset the slot fill, so packing continues across line boundaries.
- R9: In compressed mode, a frame end with a partly filled word emits that word one cycle later, with the unfilled lanes zero.
- R10: In uncompressed mode, a frame end discards a partly filled word and emits nothing. The next frame starts at the lowest lane.
- R11: Configuration inputs are sampled only on a frame-start cycle. Changes during a frame take effect at the next frame.
- R12: A sample is ignored in three cases: it arrives before the first frame start, it arrives after a frame end and before the next frame start, or it arrives in the same cycle as any marker.
- R13: wordValid is a single-cycle pulse. It follows the edge that captured the completing sample or the frame-end marker.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| sampleIn | input | 14 | Pixel sample, LSB aligned |
| sampleValid | input | 1 | Sample qualifier |
| lineStart | input | 1 | Line-start marker pulse |
| frameStart | input | 1 | Frame-start marker pulse, latches configuration |
| frameEnd | input | 1 | Frame-end marker pulse |
| widthSel | input | 2 | Sample width code: 00=8, 01=10, 10=12, 11=14 bits |
| byteSelMode | input | 2 | In-line decimation mode for 8-bit samples |
| byteSelPhase | input | 1 | In-line decimation phase |
| lineSelEn | input | 1 | Keep one line of every two |
| lineSelPhase | input | 1 | Line parity to keep |
| compressedMode | input | 1 | Pad and emit a partial word at frame end |
| wordOut | output | 32 | Packed little-endian word |
| wordValid | output | 1 | Word strobe |

## Verification
All decimation and packing decisions are combinational on the capture edge. A word completed by a sample therefore shows on wordOut with wordValid high exactly one clock after that sample's edge. A padded word likewise appears one clock after the frame-end edge. Nothing else is registered on the way.

The bench drives every input one time unit after a rising edge. Its monitor samples on the falling edge, so each expected word is compared in the half cycle after it becomes due. Every word the reference model predicts is queued when its last sample or frame end is driven. A word the monitor sees with nothing queued is a failure, and so is a queue that has not drained two clocks after a frame end.

// File: rtl/pwp_pkg.sv
package pwp_pkg;

  typedef enum logic [1:0] {
    WID_8  = 2'b00,
    WID_10 = 2'b01,
    WID_12 = 2'b10,
    WID_14 = 2'b11
  } pwp_width_e;

  typedef enum logic [1:0] {
    BSEL_ALL     = 2'b00,
    BSEL_HALF    = 2'b01,
    BSEL_QUARTER = 2'b10,
    BSEL_PAIR    = 2'b11
  } pwp_bsel_e;

  typedef struct packed {
    logic [1:0] width;
    logic [1:0] byteMode;
    logic       bytePhase;
    logic       lineEn;
    logic       linePhase;
    logic       compressed;
  } pwp_cfg_t;

  typedef struct packed {
    logic accept;
    logic flush;
    logic clear;
  } pwp_strobe_t;

endpackage

// File: rtl/pwp_control.sv
module pwp_control
  import pwp_pkg::*;
#(
  parameter int DECIM_SPAN = 4
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        sampleValid,
  input  logic        lineStart,
  input  logic        frameStart,
  input  logic        frameEnd,
  input  pwp_cfg_t    cfgIn,
  output pwp_cfg_t    cfgLat,
  output pwp_strobe_t strobe
);
  localparam int POS_W = $clog2(DECIM_SPAN);

  logic             active;
  logic             firstLine;
  logic             lineOdd;
  logic [POS_W-1:0] bytePos;
  logic             lineKept;
  logic             byteKept;
  logic             anyMarker;

  always_comb begin
    lineKept = !cfgLat.lineEn || (lineOdd == cfgLat.linePhase);
    byteKept = 1'b1;
    if (cfgLat.width == WID_8) begin
      case (cfgLat.byteMode)
        BSEL_HALF:    byteKept = (bytePos[0] == cfgLat.bytePhase);
        BSEL_QUARTER: byteKept = (bytePos == POS_W'(cfgLat.bytePhase));
        BSEL_PAIR:    byteKept = (bytePos[POS_W-1] == cfgLat.bytePhase);
        default:      byteKept = 1'b1;
      endcase
    end
  end

  always_comb begin
    anyMarker     = frameStart || frameEnd || lineStart;
    strobe.accept = sampleValid && !anyMarker && active && lineKept && byteKept;
    strobe.flush  = !frameStart && frameEnd && active && cfgLat.compressed;
    strobe.clear  = frameStart || (frameEnd && !strobe.flush);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfgLat    <= '0;
      active    <= 1'b0;
      firstLine <= 1'b1;
      lineOdd   <= 1'b0;
      bytePos   <= '0;
    end else if (frameStart) begin
      cfgLat    <= cfgIn;
      active    <= 1'b1;
      firstLine <= 1'b1;
      lineOdd   <= 1'b0;
      bytePos   <= '0;
    end else if (frameEnd) begin
      active    <= 1'b0;
    end else if (lineStart) begin
      if (active) begin
        bytePos <= '0;
        if (firstLine) firstLine <= 1'b0;
        else           lineOdd   <= ~lineOdd;
      end
    end else if (sampleValid && active && lineKept) begin
      bytePos <= bytePos + 1'b1;
    end
  end

endmodule

// File: rtl/pwp_datapath.sv
module pwp_datapath
  import pwp_pkg::*;
#(
  parameter int SAMPLE_W = 14,
  parameter int WORD_W   = 32,
  parameter int NARROW_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [SAMPLE_W-1:0] sampleIn,
  input  logic [1:0]        width,
  input  pwp_strobe_t       strobe,
  output logic [WORD_W-1:0] wordOut,
  output logic              wordValid
);
  localparam int SLOT_W       = WORD_W / 2;
  localparam int NARROW_SLOTS = WORD_W / NARROW_W;
  localparam int SLOT_CNT_W   = $clog2(NARROW_SLOTS);
  localparam int WIDTH_CODES  = 4;

  logic [SAMPLE_W-1:0]   masked [WIDTH_CODES];
  logic [WORD_W-1:0]     acc;
  logic [WORD_W-1:0]     placed;
  logic [SLOT_CNT_W-1:0] slot;
  logic [SLOT_CNT_W-1:0] lastSlot;
  logic                  narrow;
  logic [SLOT_W-1:0]     wideSample;

  for (genvar g = 0; g < WIDTH_CODES; g++) begin : g_mask
    localparam int BITS = NARROW_W + 2 * g;
    assign masked[g] = sampleIn & SAMPLE_W'((64'd1 << BITS) - 64'd1);
  end

  always_comb begin
    narrow     = (width == WID_8);
    lastSlot   = narrow ? SLOT_CNT_W'(NARROW_SLOTS - 1) : SLOT_CNT_W'(1);
    wideSample = SLOT_W'(masked[width]);
    placed     = acc;
    if (narrow) placed[slot*NARROW_W +: NARROW_W] = masked[0][NARROW_W-1:0];
    else        placed[slot[0]*SLOT_W +: SLOT_W]  = wideSample;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      acc       <= '0;
      slot      <= '0;
      wordOut   <= '0;
      wordValid <= 1'b0;
    end else begin
      wordValid <= 1'b0;
      if (strobe.clear) begin
        acc  <= '0;
        slot <= '0;
      end else if (strobe.flush) begin
        if (slot != '0) begin
          wordOut   <= acc;
          wordValid <= 1'b1;
        end
        acc  <= '0;
        slot <= '0;
      end else if (strobe.accept) begin
        if (slot == lastSlot) begin
          wordOut   <= placed;
          wordValid <= 1'b1;
          acc       <= '0;
          slot      <= '0;
        end else begin
          acc  <= placed;
          slot <= slot + 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/pixel_word_packer.sv
module pixel_word_packer
  import pwp_pkg::*;
#(
  parameter int SAMPLE_W   = 14,
  parameter int WORD_W     = 32,
  parameter int DECIM_SPAN = 4
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [SAMPLE_W-1:0] sampleIn,
  input  logic                sampleValid,
  input  logic                lineStart,
  input  logic                frameStart,
  input  logic                frameEnd,
  input  logic [1:0]          widthSel,
  input  logic [1:0]          byteSelMode,
  input  logic                byteSelPhase,
  input  logic                lineSelEn,
  input  logic                lineSelPhase,
  input  logic                compressedMode,
  output logic [WORD_W-1:0]   wordOut,
  output logic                wordValid
);
  pwp_cfg_t    cfgIn;
  pwp_cfg_t    cfgLat;
  pwp_strobe_t strobe;
  logic [1:0]  cfgWidthLat;
  logic        cfgCompLat;

  assign cfgIn = '{width: widthSel, byteMode: byteSelMode, bytePhase: byteSelPhase,
                   lineEn: lineSelEn, linePhase: lineSelPhase, compressed: compressedMode};
  assign cfgWidthLat = cfgLat.width;
  assign cfgCompLat  = cfgLat.compressed;

  pwp_control #(.DECIM_SPAN(DECIM_SPAN)) i_ctrl (
    .clk(clk), .rstN(rstN), .sampleValid(sampleValid), .lineStart(lineStart),
    .frameStart(frameStart), .frameEnd(frameEnd), .cfgIn(cfgIn),
    .cfgLat(cfgLat), .strobe(strobe)
  );

  pwp_datapath #(.SAMPLE_W(SAMPLE_W), .WORD_W(WORD_W)) i_data (
    .clk(clk), .rstN(rstN), .sampleIn(sampleIn), .width(cfgWidthLat),
    .strobe(strobe), .wordOut(wordOut), .wordValid(wordValid)
  );

endmodule

// File: rtl/pwp_checker.sv
module pwp_checker (
  input logic        clk,
  input logic        rstN,
  input logic        sampleValid,
  input logic        frameStart,
  input logic        frameEnd,
  input logic        wordValid,
  input logic [31:0] wordOut,
  input logic [1:0]  cfgWidth,
  input logic        cfgCompressed
);
  logic inFrameChk;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)           inFrameChk <= 1'b0;
    else if (frameStart) inFrameChk <= 1'b1;
    else if (frameEnd)   inFrameChk <= 1'b0;
  end

  // R13
  word_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
    wordValid |-> ($past(sampleValid) || $past(frameEnd)));

  // R13
  single_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    wordValid |=> !wordValid);

  // R12
  word_in_frame_chk: assert property (@(posedge clk) disable iff (!rstN)
    wordValid |-> $past(inFrameChk));

  // R9
  pad_compressed_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wordValid && $past(frameEnd)) |-> $past(cfgCompressed));

  // R10
  drop_partial_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($past(frameEnd) && !$past(cfgCompressed)) |-> !wordValid);

  // R3
  wide_upper_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wordValid && $past(cfgWidth) != 2'b00) |-> (wordOut[15:14] == 2'b00 && wordOut[31:30] == 2'b00));

  // R3
  ten_bit_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wordValid && $past(cfgWidth) == 2'b01) |-> (wordOut[15:10] == '0 && wordOut[31:26] == '0));

endmodule

bind pixel_word_packer pwp_checker i_pwp_checker (
  .clk(clk), .rstN(rstN), .sampleValid(sampleValid), .frameStart(frameStart),
  .frameEnd(frameEnd), .wordValid(wordValid), .wordOut(wordOut),
  .cfgWidth(cfgWidthLat), .cfgCompressed(cfgCompLat)
);

// File: tb/test_pixel_word_packer.sv
module test_pixel_word_packer;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [13:0] sampleIn = '0;
  logic        sampleValid = 1'b0, lineStart = 1'b0, frameStart = 1'b0, frameEnd = 1'b0;
  logic [1:0]  widthSel = '0, byteSelMode = '0;
  logic        byteSelPhase = 1'b0, lineSelEn = 1'b0, lineSelPhase = 1'b0, compressedMode = 1'b0;
  logic [31:0] wordOut;
  logic        wordValid;

  int testCount = 0;
  int failCount = 0;
  string curReq = "R1";
  logic [31:0] expQ[$];
  int cycles = 0;

  // reference model state
  bit      mIn = 0, mFirstLine = 1, mComp = 0, mLsm = 0, mLsp = 0, mBsp = 0;
  int      mW = 0, mBsm = 0, mPos = 0, mLine = 0, mSlot = 0;
  logic [31:0] mWord = '0;

  always #5 clk = ~clk;

  pixel_word_packer i_pixel_word_packer (
    .clk(clk), .rstN(rstN), .sampleIn(sampleIn), .sampleValid(sampleValid),
    .lineStart(lineStart), .frameStart(frameStart), .frameEnd(frameEnd),
    .widthSel(widthSel), .byteSelMode(byteSelMode), .byteSelPhase(byteSelPhase),
    .lineSelEn(lineSelEn), .lineSelPhase(lineSelPhase), .compressedMode(compressedMode),
    .wordOut(wordOut), .wordValid(wordValid)
  );

  task automatic finishRun();
    $display("  [TB] %0d tests run, %0d failed", testCount, failCount);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      testCount++; failCount++;
      $display("FAIL watchdog (%s): actual hung run, expected completion", curReq);
      finishRun();
    end
  end

  // scoreboard monitor
  always @(negedge clk) begin
    if (rstN && wordValid) begin
      testCount++;
      if (expQ.size() == 0) begin
        failCount++;
        $display("FAIL %s: unexpected word actual %08h expected none", curReq, wordOut);
      end else begin
        logic [31:0] e;
        e = expQ.pop_front();
        if (wordOut !== e) begin
          failCount++;
          $display("FAIL %s: word actual %08h expected %08h", curReq, wordOut, e);
        end
      end
    end
  end

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic modelSample(input logic [13:0] v);
    bit keep;
    logic [31:0] lane;
    if (!mIn) return;
    if (mLsm && ((mLine % 2) != mLsp)) return;
    keep = 1;
    if (mW == 0) begin
      case (mBsm)
        1: keep = ((mPos % 2) == mBsp);
        2: keep = ((mPos % 4) == mBsp);
        3: keep = (((mPos % 4) / 2) == mBsp);
        default: keep = 1;
      endcase
    end
    mPos++;
    if (!keep) return;
    if (mW == 0) begin
      lane  = 32'(v & 14'h00FF);
      mWord = mWord | (lane << (8 * mSlot));
      mSlot++;
      if (mSlot == 4) begin expQ.push_back(mWord); mWord = '0; mSlot = 0; end
    end else begin
      lane  = 32'(v) & ((32'd1 << (8 + 2 * mW)) - 32'd1);
      mWord = mWord | (lane << (16 * mSlot));
      mSlot++;
      if (mSlot == 2) begin expQ.push_back(mWord); mWord = '0; mSlot = 0; end
    end
  endtask

  task automatic startFrame(input int w, input int bsm, input bit bsp,
                            input bit lsm, input bit lsp, input bit comp);
    widthSel = 2'(w); byteSelMode = 2'(bsm); byteSelPhase = bsp;
    lineSelEn = lsm; lineSelPhase = lsp; compressedMode = comp;
    frameStart = 1'b1;
    mW = w; mBsm = bsm; mBsp = bsp; mLsm = lsm; mLsp = lsp; mComp = comp;
    mIn = 1; mFirstLine = 1; mLine = 0; mPos = 0; mSlot = 0; mWord = '0;
    tick();
    frameStart = 1'b0;
  endtask

  task automatic modelLine();
    if (!mIn) return;
    mPos = 0;
    if (mFirstLine) mFirstLine = 0;
    else mLine++;
  endtask

  task automatic newLine();
    lineStart = 1'b1;
    modelLine();
    tick();
    lineStart = 1'b0;
  endtask

  task automatic pushSample(input logic [13:0] v);
    sampleValid = 1'b1; sampleIn = v;
    modelSample(v);
    tick();
    sampleValid = 1'b0;
  endtask

  task automatic lineWithSample(input logic [13:0] v);
    lineStart = 1'b1; sampleValid = 1'b1; sampleIn = v;
    modelLine();
    tick();
    lineStart = 1'b0; sampleValid = 1'b0;
  endtask

  task automatic checkDrained();
    testCount++;
    if (expQ.size() != 0) begin
      failCount++;
      $display("FAIL %s: pending words actual %0d expected 0", curReq, expQ.size());
      expQ.delete();
    end
  endtask

  task automatic endFrame();
    frameEnd = 1'b1;
    if (mIn && mComp && mSlot != 0) expQ.push_back(mWord);
    mIn = 0; mSlot = 0; mWord = '0;
    tick();
    frameEnd = 1'b0;
    tick(); tick();
    checkDrained();
  endtask

  task automatic burst(input int n, input logic [13:0] base);
    for (int i = 0; i < n; i++) pushSample(base + 14'(i * 7));
  endtask

  initial begin
    repeat (3) tick();
    // R1: reset state
    curReq = "R1";
    testCount++;
    if (wordValid !== 1'b0 || wordOut !== 32'h0) begin
      failCount++;
      $display("FAIL R1: reset actual valid=%b word=%08h expected 0/00000000", wordValid, wordOut);
    end
    rstN = 1'b1;
    tick();
    testCount++;
    if (wordValid !== 1'b0 || wordOut !== 32'h0) begin
      failCount++;
      $display("FAIL R1: after release actual valid=%b word=%08h expected 0/00000000", wordValid, wordOut);
    end

    // R12: samples before any frame start
    curReq = "R12";
    burst(6, 14'h0123);
    tick(); checkDrained();

    // R2: narrow packing, upper input bits ignored
    curReq = "R2";
    startFrame(0, 0, 0, 0, 0, 0);
    pushSample(14'h3F11); pushSample(14'h2A22); pushSample(14'h1533); pushSample(14'h0044);
    pushSample(14'h3FAB); pushSample(14'h00CD); pushSample(14'h3FEF); pushSample(14'h1201);
    endFrame();

    // R3: wide widths 10, 12, 14
    curReq = "R3";
    for (int w = 1; w < 4; w++) begin
      startFrame(w, 0, 0, 0, 0, 0);
      pushSample(14'h3FFF); pushSample(14'h2AAA); pushSample(14'h1555); pushSample(14'h0F0F);
      endFrame();
    end

    // R4 and R5: in-line decimation modes and phases
    for (int m = 1; m < 4; m++) begin
      for (int p = 0; p < 2; p++) begin
        curReq = (p == 0) ? "R4" : "R5";
        startFrame(0, m, p[0], 0, 0, 0);
        burst(16, 14'h0010);
        newLine();
        burst(16, 14'h0080);
        endFrame();
      end
    end

    // R6: byte-select ignored for wide samples
    curReq = "R6";
    startFrame(2, 2, 1, 0, 0, 0);
    pushSample(14'h0ABC); pushSample(14'h0123); pushSample(14'h0FED); pushSample(14'h0456);
    endFrame();

    // R7: line decimation, both phases
    for (int p = 0; p < 2; p++) begin
      curReq = "R7";
      startFrame(0, 0, 0, 1, p[0], 0);
      for (int l = 0; l < 4; l++) begin
        newLine();
        burst(4, 14'(16 * (l + 1)));
      end
      endFrame();
    end

    // R8: line start resets decimation but not the slot fill
    curReq = "R8";
    startFrame(0, 1, 0, 0, 0, 0);
    newLine();
    burst(3, 14'h0021);
    newLine();
    burst(5, 14'h0051);
    newLine();
    burst(7, 14'h0091);
    endFrame();

    // R9: compressed stream pads partial words
    curReq = "R9";
    startFrame(0, 0, 0, 0, 0, 1);
    burst(5, 14'h0031);
    endFrame();
    startFrame(3, 0, 0, 0, 0, 1);
    burst(3, 14'h1357);
    endFrame();
    startFrame(0, 0, 0, 0, 0, 1);
    burst(4, 14'h0061);
    endFrame();

    // R10: uncompressed end drops partial word, next frame starts fresh
    curReq = "R10";
    startFrame(0, 0, 0, 0, 0, 0);
    burst(6, 14'h0071);
    endFrame();
    startFrame(0, 0, 0, 0, 0, 0);
    burst(4, 14'h00A1);
    endFrame();

    // R11: mid-frame configuration changes ignored
    curReq = "R11";
    startFrame(0, 0, 0, 0, 0, 0);
    pushSample(14'h0011);
    widthSel = 2'b11; byteSelMode = 2'b01; lineSelEn = 1'b1; lineSelPhase = 1'b1; compressedMode = 1'b1;
    burst(6, 14'h3F22);
    newLine();
    burst(5, 14'h0033);
    endFrame();

    // R12: samples after frame end and with markers
    curReq = "R12";
    burst(5, 14'h0044);
    tick(); checkDrained();
    startFrame(0, 0, 0, 0, 0, 0);
    lineWithSample(14'h00EE);
    burst(4, 14'h0055);
    endFrame();

    // R13: back-to-back wide words
    curReq = "R13";
    startFrame(1, 0, 0, 0, 0, 0);
    burst(8, 14'h0101);
    endFrame();

    finishRun();
  end
endmodule